// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of one cache line after a miss. The CPU side presents a miss with a byte address. The controller then sends one burst request to the next memory level. In critical-word-first mode the burst starts at the word that missed and wraps around the line. In early-restart mode the burst starts at word zero and runs in plain ascending order. As each word comes back, the controller writes it into the line at its true position and sets that word's bit in a per-word valid mask. The word the CPU asked for is also forwarded together with a one-cycle restart strobe, so the CPU can resume before the line is complete.

The line is 64 bytes, made of eight 64-bit words. The next level returns its first word 11 cycles after the request and each later word 2 cycles after the previous one. The whole line therefore arrives in 25 cycles. In critical-word-first mode the CPU restarts on the first returned word. In early-restart mode it restarts on the returned word whose offset matches the miss. The rest of the line keeps filling after the restart. The line is flagged complete only when all eight words are in. Tag update and the choice of victim are handled elsewhere.

Top module: `refill_cwf`

## Requirements
- R1: `missReady` is high only while no refill is in progress. A miss is accepted only in a cycle where `missValid` and `missReady` are both high. A miss presented during a refill is refused and has no effect.
- R2: `memReq` is high for exactly one cycle, the cycle after acceptance. `memAddr` holds the line base with word field bits [5:3] set to the start word and bits [2:0] zero. The start word is the missed word `missAddr[5:3]` when `cwfMode`=1, and 0 when `cwfMode`=0.
- R3: With `cwfMode`=1, `restart` pulses one cycle after the first returned word (request cycle + 12), and `fwdData` carries that word.
- R4: With `cwfMode`=0, `restart` pulses one cycle after returned word number k, where k is the missed offset (request cycle + 12 + 2k), and `fwdData` carries that word.
- R5: Returned word i (counted from 0) is written one cycle after it arrives, with `lineWrIdx` = (start + i) mod 8 and `lineWrData` equal to the returned data.
- R6: `lineMask` is cleared when a miss is accepted. Bit n is set in the same cycle that word n is written.
- R7: `fillDone` pulses for one cycle, one cycle after the eighth word arrives. `lineValid` rises in that same cycle, and it stays low from acceptance until then.
- R8: `restart` pulses exactly once per refill.
- R9: `memDataValid` outside a refill causes no line write, no restart, and no change to the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | CPU miss request |
| missAddr | input | ADDR_W | Byte address of the missed access |
| cwfMode | input | 1 | 1: critical word first, 0: early restart |
| missReady | output | 1 | Controller can take a miss |
| memReq | output | 1 | One-cycle burst request to the next level |
| memAddr | output | ADDR_W | Byte address of the first word of the burst |
| memDataValid | input | 1 | A returned word is present |
| memData | input | DATA_W | Returned word |
| restart | output | 1 | Requested word is on `fwdData`; CPU may resume |
| fwdData | output | DATA_W | Word forwarded to the CPU |
| lineWrEn | output | 1 | Write one word into the line |
| lineWrIdx | output | IDX_W | Word position in the line |
| lineWrData | output | DATA_W | Word to write |
| lineMask | output | WORDS | Per-word valid bits of the line being filled |
| lineValid | output | 1 | All words of the line are present |
| fillDone | output | 1 | One-cycle pulse when the refill completes |

## Verification
The assertions assume that the next level sends exactly eight words per request, and only after that request. They also assume it never sends a word in the cycle of the request itself. The bench models the next level to match: each burst is started from the observed request, with words in the request's wrap order, the first 11 cycles after the request and the rest 2 cycles apart. The only other data-valid pulse the bench drives is a deliberate stray pulse while idle. A second miss is presented in the middle of a fill to show that it is refused. Every offset is run in both modes.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } refillState_e;

  typedef struct packed {
    logic accept;
    logic beat;
    logic last;
    logic hit;
  } refillStrb_t;
endpackage

// File: rtl/refill_ctl.sv
module refill_ctl
  import refill_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic [IDX_W-1:0] missOff,
  input  logic             cwfMode,
  input  logic             memDataValid,
  output logic             missReady,
  output logic             memReq,
  output logic [IDX_W-1:0] startOff,
  output logic [IDX_W-1:0] wordIdx,
  output refillStrb_t      strb
);
  localparam logic [IDX_W-1:0] LAST_BEAT = {IDX_W{1'b1}};

  refillState_e state;
  logic [IDX_W-1:0] beatCnt;
  logic [IDX_W-1:0] offQ;

  assign missReady   = (state == ST_IDLE);
  assign memReq      = (state == ST_ISSUE);
  assign wordIdx     = startOff + beatCnt;
  assign strb.accept = missReady && missValid;
  assign strb.beat   = (state == ST_FILL) && memDataValid;
  assign strb.last   = strb.beat && (beatCnt == LAST_BEAT);
  assign strb.hit    = strb.beat && (wordIdx == offQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatCnt  <= '0;
      offQ     <= '0;
      startOff <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strb.accept) begin
          state    <= ST_ISSUE;
          offQ     <= missOff;
          startOff <= cwfMode ? missOff : '0;
        end
        ST_ISSUE: begin
          state   <= ST_FILL;
          beatCnt <= '0;
        end
        ST_FILL: if (strb.beat) begin
          beatCnt <= beatCnt + 1'b1;
          if (strb.last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> (!missReady && memReq));
endmodule

// File: rtl/refill_dp.sv
module refill_dp
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORDS  = 8,
  parameter int IDX_W  = 3,
  parameter int BOFF_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  refillStrb_t       strb,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [IDX_W-1:0]  startOff,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              restart,
  output logic [DATA_W-1:0] fwdData,
  output logic              lineWrEn,
  output logic [IDX_W-1:0]  lineWrIdx,
  output logic [DATA_W-1:0] lineWrData,
  output logic [WORDS-1:0]  lineMask,
  output logic              lineValid,
  output logic              fillDone
);
  localparam int LINE_LSB = IDX_W + BOFF_W;

  logic [ADDR_W-LINE_LSB-1:0] lineBaseQ;

  assign memAddr = {lineBaseQ, startOff, {BOFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBaseQ  <= '0;
      restart    <= 1'b0;
      fwdData    <= '0;
      lineWrEn   <= 1'b0;
      lineWrIdx  <= '0;
      lineWrData <= '0;
      lineValid  <= 1'b0;
      fillDone   <= 1'b0;
    end else begin
      if (strb.accept) lineBaseQ <= missAddr[ADDR_W-1:LINE_LSB];
      restart  <= strb.hit;
      lineWrEn <= strb.beat;
      fillDone <= strb.last;
      if (strb.hit) fwdData <= memData;
      if (strb.beat) begin
        lineWrIdx  <= wordIdx;
        lineWrData <= memData;
      end
      if (strb.accept)    lineValid <= 1'b0;
      else if (strb.last) lineValid <= 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN)                                   lineMask[w] <= 1'b0;
      else if (strb.accept)                        lineMask[w] <= 1'b0;
      else if (strb.beat && (wordIdx == IDX_W'(w))) lineMask[w] <= 1'b1;
    end
  end

  p_fwd_with_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> lineWrEn);
  p_mask_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineWrEn |-> lineMask[lineWrIdx]);
  p_done_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> (lineValid && (&lineMask)));
  p_restart_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !restart);
endmodule

// File: rtl/refill_cwf.sv
module refill_cwf
  import refill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int WORDS      = 8,
  parameter int WORD_BYTES = 8,
  parameter int IDX_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              cwfMode,
  output logic              missReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memDataValid,
  input  logic [DATA_W-1:0] memData,
  output logic              restart,
  output logic [DATA_W-1:0] fwdData,
  output logic              lineWrEn,
  output logic [IDX_W-1:0]  lineWrIdx,
  output logic [DATA_W-1:0] lineWrData,
  output logic [WORDS-1:0]  lineMask,
  output logic              lineValid,
  output logic              fillDone
);
  localparam int BOFF_W = $clog2(WORD_BYTES);

  refillStrb_t      strb;
  logic [IDX_W-1:0] startOff;
  logic [IDX_W-1:0] wordIdx;

  refill_ctl #(.IDX_W(IDX_W)) ctl_i (
    .clk(clk), .rstN(rstN), .missValid(missValid),
    .missOff(missAddr[BOFF_W +: IDX_W]), .cwfMode(cwfMode),
    .memDataValid(memDataValid), .missReady(missReady), .memReq(memReq),
    .startOff(startOff), .wordIdx(wordIdx), .strb(strb)
  );

  refill_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .IDX_W(IDX_W), .BOFF_W(BOFF_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .missAddr(missAddr),
    .startOff(startOff), .wordIdx(wordIdx), .memData(memData),
    .memAddr(memAddr), .restart(restart), .fwdData(fwdData),
    .lineWrEn(lineWrEn), .lineWrIdx(lineWrIdx), .lineWrData(lineWrData),
    .lineMask(lineMask), .lineValid(lineValid), .fillDone(fillDone)
  );
endmodule

// File: tb/refill_cwf_tb_top.sv
module refill_cwf_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        cwfMode = 1'b0;
  logic        missReady, memReq, restart, lineWrEn, lineValid, fillDone;
  logic [31:0] memAddr;
  logic        memDataValid = 1'b0;
  logic [63:0] memData = '0;
  logic [63:0] fwdData, lineWrData;
  logic [2:0]  lineWrIdx;
  logic [7:0]  lineMask;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  refill_cwf dut_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .cwfMode(cwfMode), .missReady(missReady), .memReq(memReq),
    .memAddr(memAddr), .memDataValid(memDataValid), .memData(memData),
    .restart(restart), .fwdData(fwdData), .lineWrEn(lineWrEn),
    .lineWrIdx(lineWrIdx), .lineWrData(lineWrData), .lineMask(lineMask),
    .lineValid(lineValid), .fillDone(fillDone)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a, input int w);
    return 64'hC0DE_0000_0000_0000 | (64'(a[31:6]) << 8) | 64'(w);
  endfunction

  // Reference: request in rel. cycle 1; word i arrives in rel. cycle 12+2i
  // (11 after request, 2 apart); outputs show one cycle later.
  task automatic runMiss(input logic [31:0] addr, input bit cwf, input bit poke);
    int off = int'(addr[5:3]);
    int start = cwf ? off : 0;
    int restartJ = 13 + 2 * (cwf ? 0 : off);
    logic [7:0] m = '0;
    @(negedge clk);
    chk(missReady == 1'b1, "R1", 64'(missReady), 64'd1);
    missValid = 1'b1; missAddr = addr; cwfMode = cwf;
    for (int j = 1; j <= 28; j++) begin
      @(negedge clk);
      chk(memReq == (j == 1), "R2", 64'(memReq), 64'(j == 1));
      if (j == 1)
        chk(memAddr == {addr[31:6], 3'(start), 3'b000}, "R2", 64'(memAddr),
            64'({addr[31:6], 3'(start), 3'b000}));
      chk(missReady == (j >= 27), "R1", 64'(missReady), 64'(j >= 27));
      begin
        bit isOut = (j >= 13) && (j <= 27) && (j % 2 == 1);
        int widx = (start + (j - 13) / 2) % 8;
        chk(lineWrEn == isOut, "R5", 64'(lineWrEn), 64'(isOut));
        if (isOut) begin
          chk(lineWrIdx == 3'(widx), "R5", 64'(lineWrIdx), 64'(widx));
          chk(lineWrData == pat(addr, widx), "R5", lineWrData, pat(addr, widx));
          m[widx] = 1'b1;
        end
        chk(lineMask == m, "R6", 64'(lineMask), 64'(m));
        chk(restart == (j == restartJ), cwf ? "R3" : "R4", 64'(restart),
            64'(j == restartJ));
        if (j == restartJ)
          chk(fwdData == pat(addr, off), cwf ? "R3" : "R4", fwdData, pat(addr, off));
        chk(fillDone == (j == 27), "R7", 64'(fillDone), 64'(j == 27));
        chk(lineValid == (j >= 27), "R7", 64'(lineValid), 64'(j >= 27));
      end
      // R1: a second miss during the fill must be refused
      missValid = poke && (j == 5);
      if (poke && j == 5) missAddr = addr ^ 32'h0000_1000;
      memDataValid = (j >= 12) && (j <= 26) && (j % 2 == 0);
      memData = memDataValid ? pat(addr, (start + (j - 12) / 2) % 8) : 64'hDEAD;
    end
    // R8: no second restart after the fill
    chk(restart == 1'b0, "R8", 64'(restart), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(missReady == 1'b1, "R1", 64'(missReady), 64'd1);
    chk(memReq == 1'b0, "R2", 64'(memReq), 64'd0);
    chk(restart == 1'b0, "R8", 64'(restart), 64'd0);
    chk(lineMask == 8'h00, "R6", 64'(lineMask), 64'd0);
    chk(lineValid == 1'b0, "R7", 64'(lineValid), 64'd0);
    // R9: stray data while idle, before any refill
    memDataValid = 1'b1; memData = 64'h1111;
    @(negedge clk);
    memDataValid = 1'b0;
    @(negedge clk);
    chk(lineWrEn == 1'b0 && restart == 1'b0, "R9", 64'({lineWrEn, restart}), 64'd0);
    chk(lineMask == 8'h00, "R9", 64'(lineMask), 64'd0);
    for (int o = 0; o < 8; o++)
      runMiss(32'h8000_0000 | (32'(o) << 3) | (32'(o) << 8), 1'b1, o == 3);
    for (int o = 0; o < 8; o++)
      runMiss(32'h4000_0004 | (32'(o) << 3) | (32'(o) << 9), 1'b0, o == 6);
    // R9: stray data after a completed fill leaves the line untouched
    @(negedge clk);
    memDataValid = 1'b1; memData = 64'h2222;
    @(negedge clk);
    memDataValid = 1'b0;
    @(negedge clk);
    chk(lineWrEn == 1'b0 && restart == 1'b0, "R9", 64'({lineWrEn, restart}), 64'd0);
    chk(lineMask == 8'hFF && lineValid, "R9", 64'({lineValid, lineMask}), 64'h1FF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule